// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block accepts software-issued instruction codes for an attached serial flash device and follows each one through execution. A register write to the instruction field starts a command when the command is legal. The flash-side shifting engine is reached through a start pulse that carries the latched instruction code, and a done pulse that comes back from it. While a command executes, the block drives a busy bit and a command-access bit. When the command completes it sets a sticky transfer-finished flag. Commands that cannot be taken are dropped, and a sticky error flag records them.

The block also works with the chip's low-power control through two request/acknowledge pairs, one for module disable and one for stop. The disable request goes through an internal pipeline of `LEAD` cycles before it becomes an entry request. New commands are refused from the cycle the disable request is first seen until the block has left disable mode, so the refusal window opens `LEAD` cycles before the entry request. After the block wakes from either mode, the first accepted command is held until the flash-side clock is reported available. Every bus input passes through a gate driven by the module enable, so bus activity does not toggle internal logic while the module is not selected.

Top module: `sfcmd_seq`

## Requirements
- R1: A write with `mod_en`=1, `bus_wr`=1, `bus_addr`=0x00 and `bus_be[0]`=1, taken while the block is idle, legal and not waiting for the flash clock, raises `busy` and `cmd_act` together at the next clock edge. At that same edge, `eng_start` pulses for exactly one cycle and `eng_code` takes `bus_wdata[7:0]`.
- R2: `busy` and `cmd_act` stay high until an edge at which `eng_done` is sampled high. At that edge both fall and `xfer_done` sets.
- R3: `xfer_done` and `cmd_err` are sticky. Writing `bus_addr`=0x04 with `bus_be[0]`=1 clears `xfer_done` when `bus_wdata[0]`=1, and clears `cmd_err` when `bus_wdata[1]`=1. If a flag sets and clears in the same cycle, the set wins.
- R4: A command write sampled while `dis_req` or `dis_ack` is high is rejected. `busy` stays low, no start is issued, and `cmd_err` sets.
- R5: With the block idle, `dis_ack` rises at the third consecutive edge (LEAD+1, LEAD=2) at which `dis_req` is sampled high. It falls at the first edge at which `dis_req` is sampled low.
- R6: Neither `dis_ack` nor `stop_ack` rises while a command is executing or waiting for the flash clock. When the command ends, the held acknowledge rises one edge after the done edge.
- R7: With the block idle, `stop_ack` rises at the edge after `stop_req` is sampled high. It falls at the first edge at which `stop_req` is sampled low.
- R8: After the block leaves stop or disable mode, the first accepted command is held while `fclk_avail` is low. During that time `busy` stays low and there is no start. At the first edge where `fclk_avail` is sampled high, `busy` rises and `eng_start` pulses with the held code. Later commands are not held.
- R9: A command write while a command is executing or waiting is rejected. `cmd_err` sets, and `eng_code`, `busy` and the start pulse are unaffected.
- R10: While `mod_en` is low, bus writes have no effect: no command starts and no flag is cleared.
- R11: A synchronous active-high `rst` clears `busy`, `cmd_act`, `xfer_done`, `cmd_err`, `eng_start`, `dis_ack` and `stop_ack`, and leaves no command pending.
- R12: An `eng_done` pulse while no command is executing is ignored: `xfer_done` and `busy` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Module enable; gates all bus inputs |
| bus_addr | input | ADDR_W | Register offset of the access |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| dis_req | input | 1 | Module-disable request |
| dis_ack | output | 1 | Module-disable acknowledge (high while in disable mode) |
| stop_req | input | 1 | Stop request |
| stop_ack | output | 1 | Stop acknowledge (high while in stop mode) |
| fclk_avail | input | 1 | Flash-domain clock is running |
| eng_start | output | 1 | One-cycle start pulse to the shifting engine |
| eng_code | output | IC_W | Instruction code for the engine |
| eng_done | input | 1 | Engine finished the current instruction |
| busy | output | 1 | Command executing |
| cmd_act | output | 1 | Command-access status |
| xfer_done | output | 1 | Sticky transfer-finished flag |
| cmd_err | output | 1 | Sticky rejected-command flag |

## Verification
Some properties are checked by assertions on every cycle: busy and done move together with the flags, a rejected command never raises busy, an acknowledge never rises while a command is in flight, both acknowledges fall once their request drops, a held command never starts while the flash clock is absent, and an idle block with the module unselected stays idle. Other behaviours can only be shown by the bench scenarios. These are the exact edge on which the disable acknowledge rises, the accept/reject boundary as a write moves across the rise of the disable request, the deferral applying only to the first command after wake-up, sticky clearing through the flag register, and the latched code surviving a rejected write.

// File: rtl/sfcmd_pkg.sv
package sfcmd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_EXEC = 2'd2
   } seq_state_t;

   // bit positions inside the flag-clear write data
   localparam int FLG_XFER = 0;
   localparam int FLG_ERR  = 1;
   localparam int FLG_W    = 2;
endpackage

// File: rtl/sfcmd_busgate.sv
module sfcmd_busgate #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int BE_W      = DATA_W / 8,
   parameter bit HOLD_LAST = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [BE_W-1:0]   in_be,
   input  logic              in_wr,
   input  logic [DATA_W-1:0] in_wdata,
   output logic [ADDR_W-1:0] out_addr,
   output logic [BE_W-1:0]   out_be,
   output logic              out_wr,
   output logic [DATA_W-1:0] out_wdata
);
   // the write strobe is always forced low when unselected
   assign out_wr = en & in_wr;

   generate
      if (HOLD_LAST) begin : g_hold
         // unselected: present the last selected values, so nothing toggles
         logic [ADDR_W-1:0] addr_q;
         logic [BE_W-1:0]   be_q;
         logic [DATA_W-1:0] wdata_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               addr_q  <= '0;
               be_q    <= '0;
               wdata_q <= '0;
            end else if (en) begin
               addr_q  <= in_addr;
               be_q    <= in_be;
               wdata_q <= in_wdata;
            end
         end
         assign out_addr  = en ? in_addr  : addr_q;
         assign out_be    = en ? in_be    : be_q;
         assign out_wdata = en ? in_wdata : wdata_q;
      end else begin : g_zero
         // unselected: force constant zero
         assign out_addr  = in_addr  & {ADDR_W{en}};
         assign out_be    = in_be    & {BE_W{en}};
         assign out_wdata = in_wdata & {DATA_W{en}};
      end
   endgenerate
endmodule

// File: rtl/sfcmd_lpctl.sv
module sfcmd_lpctl #(
   parameter int LEAD = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic dis_req,
   input  logic stop_req,
   input  logic fclk_avail,
   input  logic core_idle,
   output logic dis_ack,
   output logic stop_ack,
   output logic cmd_illegal,
   output logic wake_pend
);
   logic [LEAD-1:0] dpipe;
   logic            entry_req;

   if (LEAD < 1) begin : g_bad_lead
      $error("sfcmd_lpctl: LEAD must be at least 1");
   end

   // counts consecutive sampled requests; a gap restarts the lead time
   generate
      if (LEAD == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst) dpipe <= '0;
            else     dpipe <= dis_req;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst)          dpipe <= '0;
            else if (dis_req) dpipe <= {dpipe[LEAD-2:0], 1'b1};
            else              dpipe <= '0;
         end
      end
   endgenerate

   assign entry_req   = dpipe[LEAD-1];
   // refusal window: opens as the request is seen, closes on leaving disable
   assign cmd_illegal = dis_req | dis_ack;

   always_ff @(posedge clk) begin
      if (rst) begin
         dis_ack   <= 1'b0;
         stop_ack  <= 1'b0;
         wake_pend <= 1'b0;
      end else begin
         if (!dis_req)                    dis_ack <= 1'b0;
         else if (entry_req && core_idle) dis_ack <= 1'b1;

         if (!stop_req)       stop_ack <= 1'b0;
         else if (core_idle)  stop_ack <= 1'b1;

         if ((dis_ack && !dis_req) || (stop_ack && !stop_req)) wake_pend <= 1'b1;
         else if (fclk_avail)                                  wake_pend <= 1'b0;
      end
   end

   p_dis_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (dis_req && !core_idle && !dis_ack) |=> !dis_ack);
   p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (stop_req && !core_idle && !stop_ack) |=> !stop_ack);
   p_dis_drop_r5: assert property (@(posedge clk) disable iff (rst)
      !dis_req |=> !dis_ack);
   p_dis_cause_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(dis_ack) |-> $past(dis_req));
   p_stop_drop_r7: assert property (@(posedge clk) disable iff (rst)
      !stop_req |=> !stop_ack);
endmodule

// File: rtl/sfcmd_core.sv
module sfcmd_core
   import sfcmd_pkg::*;
#(
   parameter int IC_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_ic,
   input  logic [IC_W-1:0]  ic_val,
   input  logic             wr_flg,
   input  logic [FLG_W-1:0] flg_clr,
   input  logic             illegal,
   input  logic             wake_pend,
   input  logic             fclk_avail,
   input  logic             eng_done,
   output logic             busy,
   output logic             cmd_act,
   output logic             idle,
   output logic             eng_start,
   output logic [IC_W-1:0]  eng_code,
   output logic             xfer_done,
   output logic             err_flag
);
   seq_state_t state;
   logic       accept, reject, finish;

   assign idle    = (state == ST_IDLE);
   assign accept  = wr_ic && !illegal && idle;
   assign reject  = wr_ic && !accept;
   assign finish  = (state == ST_EXEC) && eng_done;
   assign busy    = (state == ST_EXEC);
   assign cmd_act = busy;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         eng_start <= 1'b0;
         eng_code  <= '0;
      end else begin
         eng_start <= 1'b0;
         unique case (state)
            ST_IDLE: if (accept) begin
               eng_code <= ic_val;
               if (wake_pend && !fclk_avail) begin
                  state <= ST_WAIT;
               end else begin
                  state     <= ST_EXEC;
                  eng_start <= 1'b1;
               end
            end
            ST_WAIT: if (fclk_avail) begin
               state     <= ST_EXEC;
               eng_start <= 1'b1;
            end
            ST_EXEC: if (eng_done) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         xfer_done <= 1'b0;
         err_flag  <= 1'b0;
      end else begin
         if (finish)                          xfer_done <= 1'b1;
         else if (wr_flg && flg_clr[FLG_XFER]) xfer_done <= 1'b0;

         if (reject)                          err_flag <= 1'b1;
         else if (wr_flg && flg_clr[FLG_ERR])  err_flag <= 1'b0;
      end
   end

   p_start_with_busy_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> eng_start);
   p_done_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (busy && eng_done) |=> (!busy && !cmd_act && xfer_done));
   p_sticky_xfer_r3: assert property (@(posedge clk) disable iff (rst)
      (xfer_done && !(wr_flg && flg_clr[FLG_XFER])) |=> xfer_done);
   p_reject_window_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_ic && illegal && idle) |=> (!busy && !eng_start && err_flag));
   p_hold_no_clk_r8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && !fclk_avail) |=> (!busy && !eng_start));
   p_reject_busy_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_ic && busy && !eng_done) |=> (busy && !eng_start && err_flag && $stable(eng_code)));
   p_stray_done_r12: assert property (@(posedge clk) disable iff (rst)
      (idle && eng_done && !wr_ic && !(wr_flg && flg_clr[FLG_XFER])) |=> ($stable(xfer_done) && !busy));
endmodule

// File: rtl/sfcmd_seq.sv
module sfcmd_seq
   import sfcmd_pkg::*;
#(
   parameter int              ADDR_W     = 8,
   parameter int              DATA_W     = 32,
   parameter int              IC_W       = 8,
   parameter int              LEAD       = 2,
   parameter bit              HOLD_GATED = 1'b0,
   parameter logic [ADDR_W-1:0] IC_OFFS  = 'h00,
   parameter logic [ADDR_W-1:0] FLG_OFFS = 'h04
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mod_en,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W/8-1:0] bus_be,
   input  logic                bus_wr,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                dis_req,
   output logic                dis_ack,
   input  logic                stop_req,
   output logic                stop_ack,
   input  logic                fclk_avail,
   output logic                eng_start,
   output logic [IC_W-1:0]     eng_code,
   input  logic                eng_done,
   output logic                busy,
   output logic                cmd_act,
   output logic                xfer_done,
   output logic                cmd_err
);
   localparam int BE_W = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("sfcmd_seq: DATA_W must be a positive multiple of 8");
   end
   if (IC_W < 1 || IC_W > 8) begin : g_bad_ic
      $error("sfcmd_seq: IC_W must fit byte lane 0");
   end
   if (IC_OFFS == FLG_OFFS) begin : g_bad_offs
      $error("sfcmd_seq: register offsets must differ");
   end

   logic [ADDR_W-1:0] g_addr;
   logic [BE_W-1:0]   g_be;
   logic              g_wr;
   logic [DATA_W-1:0] g_wdata;
   logic              wr_ic, wr_flg;
   logic              illegal, wake_pend, core_idle;
   logic              spare_unused;

   sfcmd_busgate #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .HOLD_LAST(HOLD_GATED)
   ) u_gate (
      .clk(clk), .rst(rst), .en(mod_en),
      .in_addr(bus_addr), .in_be(bus_be), .in_wr(bus_wr), .in_wdata(bus_wdata),
      .out_addr(g_addr), .out_be(g_be), .out_wr(g_wr), .out_wdata(g_wdata)
   );

   assign wr_ic  = g_wr && (g_addr == IC_OFFS)  && g_be[0];
   assign wr_flg = g_wr && (g_addr == FLG_OFFS) && g_be[0];
   assign spare_unused = ^{g_be, g_wdata};

   sfcmd_lpctl #(.LEAD(LEAD)) u_lp (
      .clk(clk), .rst(rst),
      .dis_req(dis_req), .stop_req(stop_req), .fclk_avail(fclk_avail),
      .core_idle(core_idle),
      .dis_ack(dis_ack), .stop_ack(stop_ack),
      .cmd_illegal(illegal), .wake_pend(wake_pend)
   );

   sfcmd_core #(.IC_W(IC_W)) u_core (
      .clk(clk), .rst(rst),
      .wr_ic(wr_ic), .ic_val(g_wdata[IC_W-1:0]),
      .wr_flg(wr_flg), .flg_clr(g_wdata[FLG_W-1:0]),
      .illegal(illegal), .wake_pend(wake_pend), .fclk_avail(fclk_avail),
      .eng_done(eng_done),
      .busy(busy), .cmd_act(cmd_act), .idle(core_idle),
      .eng_start(eng_start), .eng_code(eng_code),
      .xfer_done(xfer_done), .err_flag(cmd_err)
   );

   p_unselected_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (!mod_en && core_idle) |=> (!busy && !eng_start));
endmodule

// File: tb/sim_sfcmd_seq.sv
module sim_sfcmd_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mod_en = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        dis_req = 1'b0, stop_req = 1'b0;
   logic        fclk_avail = 1'b1, eng_done = 1'b0;
   logic        dis_ack, stop_ack, eng_start, busy, cmd_act, xfer_done, cmd_err;
   logic [7:0]  eng_code;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   sfcmd_seq u0 (
      .clk(clk), .rst(rst), .mod_en(mod_en),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .dis_req(dis_req), .dis_ack(dis_ack), .stop_req(stop_req), .stop_ack(stop_ack),
      .fclk_avail(fclk_avail), .eng_start(eng_start), .eng_code(eng_code),
      .eng_done(eng_done), .busy(busy), .cmd_act(cmd_act),
      .xfer_done(xfer_done), .cmd_err(cmd_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_be = 4'h1; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0; bus_be = 4'h0;
   endtask

   task automatic done_pulse();
      eng_done = 1'b1;
      tick();
      eng_done = 1'b0;
   endtask

   task automatic clr_flags();
      wr(8'h04, 32'h3);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL watchdog R11 actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst = 1'b0;
      // R11 reset state
      chk("R11 busy", busy, 0);
      chk("R11 cmd_act", cmd_act, 0);
      chk("R11 xfer_done", xfer_done, 0);
      chk("R11 cmd_err", cmd_err, 0);
      chk("R11 eng_start", eng_start, 0);
      chk("R11 dis_ack", dis_ack, 0);
      chk("R11 stop_ack", stop_ack, 0);

      // R1/R2/R3: sweep instruction codes and engine latencies
      for (int c = 0; c < 32; c++) begin
         int lat;
         lat = (c % 4) + 1;
         wr(8'h00, 32'hFFFF_FF00 | (c * 7));
         chk("R1 busy", busy, 1);
         chk("R1 cmd_act", cmd_act, 1);
         chk("R1 start", eng_start, 1);
         chk("R1 code", eng_code, (c * 7) & 8'hFF);
         for (int k = 0; k < lat; k++) begin
            tick();
            chk("R1 start single", eng_start, 0);
            chk("R2 busy held", busy, 1);
         end
         done_pulse();
         chk("R2 busy fall", busy, 0);
         chk("R2 cmd_act fall", cmd_act, 0);
         chk("R2 xfer set", xfer_done, 1);
         tick();
         chk("R3 xfer sticky", xfer_done, 1);
         wr(8'h04, 32'h2);
         chk("R3 xfer kept by err clear", xfer_done, 1);
         wr(8'h04, 32'h1);
         chk("R3 xfer cleared", xfer_done, 0);
      end

      // R9: write while busy
      wr(8'h00, 32'hA5);
      wr(8'h00, 32'h3C);
      chk("R9 err", cmd_err, 1);
      chk("R9 code kept", eng_code, 32'hA5);
      chk("R9 no restart", eng_start, 0);
      chk("R9 busy", busy, 1);
      done_pulse();
      chk("R3 err sticky", cmd_err, 1);
      wr(8'h04, 32'h2);
      chk("R3 err cleared", cmd_err, 0);
      chk("R3 xfer kept by err clear", xfer_done, 1);
      clr_flags();

      // R12: stray done
      done_pulse();
      chk("R12 xfer", xfer_done, 0);
      chk("R12 busy", busy, 0);

      // R10: module not selected
      mod_en = 1'b0;
      wr(8'h00, 32'h77);
      chk("R10 no busy", busy, 0);
      chk("R10 no start", eng_start, 0);
      chk("R10 no err", cmd_err, 0);
      mod_en = 1'b1;
      wr(8'h00, 32'h12);
      done_pulse();
      mod_en = 1'b0;
      wr(8'h04, 32'h3);
      chk("R10 xfer not cleared", xfer_done, 1);
      mod_en = 1'b1;
      clr_flags();

      // R5: disable acknowledge timing, R4 in disable mode
      dis_req = 1'b1;
      tick(); chk("R5 ack edge1", dis_ack, 0);
      tick(); chk("R5 ack edge2", dis_ack, 0);
      tick(); chk("R5 ack edge3", dis_ack, 1);
      wr(8'h00, 32'h44);
      chk("R4 rejected in disable", busy, 0);
      chk("R4 err in disable", cmd_err, 1);
      dis_req = 1'b0;
      tick(); chk("R5 ack drop", dis_ack, 0);
      tick();
      clr_flags();

      // R4/R6: write moves across the rise of the disable request
      for (int k = -3; k <= 3; k++) begin
         for (int n = 0; n < 7; n++) begin
            dis_req = (n >= 3);
            if (n == 3 + k) begin
               wr(8'h00, 32'h20 + k);
               chk("R4 window accept", busy, (k < 0) ? 1 : 0);
               chk("R4 window err", cmd_err, (k < 0) ? 0 : 1);
            end else begin
               tick();
            end
         end
         if (k < 0) begin
            chk("R6 ack held while busy", dis_ack, 0);
            done_pulse();
            chk("R6 ack not on done edge", dis_ack, 0);
            tick();
            chk("R6 ack after done", dis_ack, 1);
         end else begin
            chk("R5 ack reached", dis_ack, 1);
         end
         dis_req = 1'b0;
         tick();
         chk("R5 ack drop sweep", dis_ack, 0);
         tick();
         clr_flags();
      end

      // R8: deferral after leaving disable
      dis_req = 1'b1;
      tick(); tick(); tick();
      fclk_avail = 1'b0;
      dis_req = 1'b0;
      tick();
      wr(8'h00, 32'h5A);
      chk("R8 held busy", busy, 0);
      chk("R8 held start", eng_start, 0);
      tick(); tick();
      chk("R8 still held", busy, 0);
      wr(8'h00, 32'h11);
      chk("R9 reject while waiting", cmd_err, 1);
      chk("R8 held after reject", busy, 0);
      fclk_avail = 1'b1;
      tick();
      chk("R8 start on clock", eng_start, 1);
      chk("R8 busy on clock", busy, 1);
      chk("R8 held code", eng_code, 32'h5A);
      done_pulse();
      clr_flags();
      fclk_avail = 1'b0;
      wr(8'h00, 32'h6B);
      chk("R8 only first held", busy, 1);
      done_pulse();
      fclk_avail = 1'b1;
      clr_flags();

      // R7/R6 stop handshake and deferral after stop
      stop_req = 1'b1;
      tick(); chk("R7 stop ack", stop_ack, 1);
      fclk_avail = 1'b0;
      stop_req = 1'b0;
      tick(); chk("R7 stop drop", stop_ack, 0);
      wr(8'h00, 32'h39);
      chk("R8 held after stop", busy, 0);
      fclk_avail = 1'b1;
      tick();
      chk("R8 start after stop", busy, 1);
      stop_req = 1'b1;
      tick(); tick();
      chk("R6 stop ack held", stop_ack, 0);
      done_pulse();
      tick();
      chk("R6 stop ack after done", stop_ack, 1);
      stop_req = 1'b0;
      tick();
      clr_flags();

      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule